// File: doc/BRIEF.md
# Phase-Coincidence Gated Frequency Counter

This block measures an unknown digital signal against a reference signal of known frequency, removing the one-count quantization error of plain gated counting. Both inputs are brought onto one fast sampling clock and reduced to single-cycle rising-edge pulses. The measurement gate opens on the first cycle in which both signals rise together. It closes on a later such coincidence, so the gate spans whole periods of both signals.

Inside the gate, one counter counts rising edges of the measured signal and the other counts rising edges of the reference. Downstream logic obtains the unknown frequency as the reference frequency times the measured count divided by the reference count. A programmable minimum gate sets resolution: closing coincidences are accepted only once enough reference edges have been counted. A programmable timeout ends a measurement whose closing coincidence never arrives. Results are held with a one-cycle done strobe until the next start request.

Top module: `phase_gate_freq_counter`

## Requirements
- R1: After reset, done_o, overflow_o and timeout_o are 0 and both counts read 0.
- R2: A start_i pulse while no measurement is running clears both counts and both flags and arms the block. A start_i pulse while armed or counting has no effect on the result.
- R3: While armed, the gate opens on the first sampling cycle in which both synchronized inputs show a rising edge. That opening edge is not counted. Every later rising edge of each input, up to and including the closing coincidence, adds one to that input's count.
- R4: A coincidence closes the gate only if the reference count before it is at least min_gate_i. Earlier coincidences are counted as ordinary edges and the gate stays open.
- R5: For periodic inputs with periods Pm and Pr (in sampling cycles), a result without flags satisfies meas_cnt_o*Pm == ref_cnt_o*Pr exactly.
- R6: Each measurement ends with exactly one done_o pulse, one cycle wide, within 8 cycles of the closing input edge.
- R7: After done_o, the counts and flags hold their values until the next start_i, whatever the inputs do.
- R8: Each count saturates at its all-ones value. An increment attempted at saturation sets overflow_o, which stays set until the next start.
- R9: Once the minimum gate is met, each reference rising edge that does not close the gate is a waiting edge. When the number of waiting edges reaches timeout_i, the measurement ends with timeout_o set. After a normal close, timeout_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse |
| meas_i | input | 1 | Signal under measurement (asynchronous) |
| ref_i | input | 1 | Reference timebase signal (asynchronous) |
| min_gate_i | input | CNT_W | Minimum reference count before a closing coincidence is accepted |
| timeout_i | input | CNT_W | Waiting reference edges allowed after the minimum gate |
| done_o | output | 1 | One-cycle result strobe |
| meas_cnt_o | output | CNT_W | Measured-signal edges inside the gate |
| ref_cnt_o | output | CNT_W | Reference edges inside the gate |
| overflow_o | output | 1 | A count saturated during the measurement |
| timeout_o | output | 1 | Measurement ended by timeout |

## Verification
The assertions assume that each high and low phase of meas_i and ref_i lasts at least two sampling cycles, so that no edge is lost in the synchronizers. They also assume that min_gate_i and timeout_i stay constant during a measurement. The stimulus uses periods of at least four cycles with half-periods of two or more, and it changes the two limits only together with a start pulse. Between measurements it holds both inputs low long enough to drain the synchronizers, so that no stale edge is seen after arming.

// File: rtl/pgfc_pkg.sv
package pgfc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_COUNT = 2'd2,
    ST_DONE  = 2'd3
  } pgfc_state_e;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_MEAS = 0;
  localparam int unsigned CH_REF  = 1;
endpackage

// File: rtl/pgfc_rise_sync.sv
module pgfc_rise_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pgfc_sat_cnt.sv
module pgfc_sat_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         sat_hit_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;
  logic         at_max;

  assign at_max = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (inc_i && !at_max) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign sat_hit_o = inc_i & at_max & ~clr_i;
endmodule

// File: rtl/pgfc_ctrl.sv
module pgfc_ctrl
  import pgfc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        rise_meas_i,
  input  logic        rise_ref_i,
  input  logic [W-1:0] ref_cnt_i,
  input  logic [W-1:0] min_gate_i,
  input  logic [W-1:0] timeout_i,
  input  logic        sat_hit_i,
  output logic        clr_o,
  output logic        inc_meas_o,
  output logic        inc_ref_o,
  output pgfc_state_e state_o,
  output logic        done_o,
  output logic        overflow_o,
  output logic        timeout_o
);
  pgfc_state_e state_q, state_d;
  logic [W-1:0] wait_q;
  logic [W:0]   wait_nxt;
  logic         coin, counting, gate_met, stop_ok, wait_edge, tmo_hit, finish;
  logic         done_q, ovf_q, tmo_q;

  assign coin      = rise_meas_i & rise_ref_i;
  assign counting  = (state_q == ST_COUNT);
  assign gate_met  = (ref_cnt_i >= min_gate_i);
  assign stop_ok   = counting & coin & gate_met;
  assign wait_edge = counting & rise_ref_i & gate_met & ~coin;
  assign wait_nxt  = {1'b0, wait_q} + 1'b1;
  assign tmo_hit   = wait_edge & (wait_nxt >= {1'b0, timeout_i});
  assign finish    = stop_ok | tmo_hit;

  assign clr_o      = start_i & ((state_q == ST_IDLE) | (state_q == ST_DONE));
  assign inc_meas_o = counting & rise_meas_i;
  assign inc_ref_o  = counting & rise_ref_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_ARMED;
      ST_ARMED: if (coin)    state_d = ST_COUNT;
      ST_COUNT: if (finish)  state_d = ST_DONE;
      ST_DONE:  if (start_i) state_d = ST_ARMED;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (clr_o) begin
        wait_q <= '0;
        ovf_q  <= 1'b0;
        tmo_q  <= 1'b0;
      end else begin
        if (wait_edge) wait_q <= wait_nxt[W-1:0];
        if (sat_hit_i) ovf_q  <= 1'b1;
        if (tmo_hit)   tmo_q  <= 1'b1;
      end
    end
  end

  assign state_o    = state_q;
  assign done_o     = done_q;
  assign overflow_o = ovf_q;
  assign timeout_o  = tmo_q;
endmodule

// File: rtl/phase_gate_freq_counter.sv
module phase_gate_freq_counter
  import pgfc_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             meas_i,
  input  logic             ref_i,
  input  logic [CNT_W-1:0] min_gate_i,
  input  logic [CNT_W-1:0] timeout_i,
  output logic             done_o,
  output logic [CNT_W-1:0] meas_cnt_o,
  output logic [CNT_W-1:0] ref_cnt_o,
  output logic             overflow_o,
  output logic             timeout_o
);
  logic [NUM_CH-1:0] raw, rise, inc, sat_hit;
  logic [CNT_W-1:0]  cnt [NUM_CH];
  logic              clr;
  pgfc_state_e       state;

  assign raw[CH_MEAS] = meas_i;
  assign raw[CH_REF]  = ref_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pgfc_rise_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw[g]),
      .rise_o (rise[g])
    );
    pgfc_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr),
      .inc_i     (inc[g]),
      .cnt_o     (cnt[g]),
      .sat_hit_o (sat_hit[g])
    );
  end

  pgfc_ctrl #(.W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .rise_meas_i (rise[CH_MEAS]),
    .rise_ref_i  (rise[CH_REF]),
    .ref_cnt_i   (cnt[CH_REF]),
    .min_gate_i  (min_gate_i),
    .timeout_i   (timeout_i),
    .sat_hit_i   (|sat_hit),
    .clr_o       (clr),
    .inc_meas_o  (inc[CH_MEAS]),
    .inc_ref_o   (inc[CH_REF]),
    .state_o     (state),
    .done_o      (done_o),
    .overflow_o  (overflow_o),
    .timeout_o   (timeout_o)
  );

  assign meas_cnt_o = cnt[CH_MEAS];
  assign ref_cnt_o  = cnt[CH_REF];
endmodule

// File: rtl/pgfc_checker.sv
module pgfc_checker
  import pgfc_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input pgfc_state_e      state_i,
  input logic             done_i,
  input logic [CNT_W-1:0] meas_cnt_i,
  input logic [CNT_W-1:0] ref_cnt_i,
  input logic             ovf_i,
  input logic             tmo_i
);
  assert_armed_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ARMED) |-> (meas_cnt_i == '0 && ref_cnt_i == '0 && !ovf_i && !tmo_i));

  assert_count_monotonic_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_COUNT) |=> (meas_cnt_i >= $past(meas_cnt_i) && ref_cnt_i >= $past(ref_cnt_i)));

  assert_done_after_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (state_i == ST_DONE && $past(state_i) == ST_COUNT));

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  assert_result_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DONE && !start_i) |=>
      ($stable(meas_cnt_i) && $stable(ref_cnt_i) && $stable(ovf_i) && $stable(tmo_i)));

  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !start_i) |=> ovf_i);
endmodule

bind phase_gate_freq_counter pgfc_checker #(.CNT_W(CNT_W)) u_pgfc_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .state_i    (state),
  .done_i     (done_o),
  .meas_cnt_i (meas_cnt_o),
  .ref_cnt_i  (ref_cnt_o),
  .ovf_i      (overflow_o),
  .tmo_i      (timeout_o)
);

// File: tb/phase_gate_freq_counter_tb_top.sv
module phase_gate_freq_counter_tb_top;
  localparam int CW   = 8;
  localparam int CMAX = (1 << CW) - 1;

  typedef struct packed {
    logic [CW-1:0] m;
    logic [CW-1:0] r;
    logic          ov;
    logic          to;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, meas_i = 1'b0, ref_i = 1'b0;
  logic [CW-1:0] min_gate_i = '0, timeout_i = '0;
  logic done_o, overflow_o, timeout_o;
  logic [CW-1:0] meas_cnt_o, ref_cnt_o;

  int total = 0, bad = 0, done_seen = 0;
  exp_t  exp_q[$];
  string tag_q[$];
  logic  prev_done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  phase_gate_freq_counter #(.CNT_W(CW)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // monitor: pops expected results as done pulses appear
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (done_o && prev_done)
        chk(1'b0, "R6", "done wider than one cycle", 1, 0);
      if (done_o) begin
        done_seen++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "unexpected done", 1, 0);
        end else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(meas_cnt_o == e.m, t, "meas count", meas_cnt_o, e.m);
          chk(ref_cnt_o == e.r,  t, "ref count",  ref_cnt_o,  e.r);
          chk(overflow_o == e.ov, "R8", "overflow flag", overflow_o, e.ov);
          chk(timeout_o == e.to,  "R9", "timeout flag",  timeout_o,  e.to);
        end
      end
    end
    prev_done = done_o;
  end

  function automatic bit lvl(input int c, input int p, input int ofs);
    if (c < 0) return 1'b0;
    return ((c + ofs) % p) < (p / 2);
  endfunction

  // driver: generates both waveforms and a reference result for the scenario
  task automatic run_meas(input int pm, input int om, input int pr, input int ofr,
                          input int mn, input int tm, input int kill, input int smid,
                          input string tag);
    int   st, mc, rc, wt, d0;
    bit   ov, to, ended;
    exp_t e;
    @(posedge clk_i); #1;
    min_gate_i = mn[CW-1:0];
    timeout_i  = tm[CW-1:0];
    start_i    = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    chk(meas_cnt_o == 0 && ref_cnt_o == 0, "R2", "counts cleared on start",
        {meas_cnt_o, ref_cnt_o}, 0);
    chk(!overflow_o && !timeout_o, "R2", "flags cleared on start",
        {overflow_o, timeout_o}, 0);
    d0 = done_seen;
    st = 0; mc = 0; rc = 0; wt = 0; ov = 0; to = 0; ended = 0;
    for (int c = 0; c < 4000 && !ended; c++) begin
      bit lm, lr, pmv, rm, rr, coin, gm;
      lm  = (c < kill) ? lvl(c, pm, om) : 1'b0;
      pmv = (c - 1 < kill) ? lvl(c - 1, pm, om) : 1'b0;
      lr  = lvl(c, pr, ofr);
      rm  = lm & ~pmv;
      rr  = lr & ~lvl(c - 1, pr, ofr);
      coin = rm & rr;
      meas_i  = lm;
      ref_i   = lr;
      start_i = (c == smid);
      if (st == 0) begin
        if (coin) st = 1;
      end else begin
        gm = (rc >= mn);
        if (coin && gm) begin
          if (mc == CMAX) ov = 1; else mc++;
          if (rc == CMAX) ov = 1; else rc++;
          ended = 1;
        end else begin
          if (rm) begin if (mc == CMAX) ov = 1; else mc++; end
          if (rr) begin
            if (rc == CMAX) ov = 1; else rc++;
            if (gm) begin
              wt++;
              if (wt >= tm) begin to = 1; ended = 1; end
            end
          end
        end
      end
      @(posedge clk_i); #1;
    end
    meas_i = 1'b0; ref_i = 1'b0; start_i = 1'b0;
    if (ended) begin
      e.m = mc[CW-1:0]; e.r = rc[CW-1:0]; e.ov = ov; e.to = to;
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    chk(ended, tag, "scenario reached an end", ended, 1);
    repeat (8) @(posedge clk_i);
    #1;
    chk(done_seen == d0 + 1, "R6", "one done per measurement", done_seen - d0, 1);
    if (!ov && !to)
      chk(longint'(meas_cnt_o) * pm == longint'(ref_cnt_o) * pr, "R5",
          "meas*Pm vs ref*Pr", longint'(meas_cnt_o) * pm, longint'(ref_cnt_o) * pr);
    // coincident edges after done must not disturb the result
    for (int c = 0; c < 40; c++) begin
      meas_i = lvl(c, 4, 0);
      ref_i  = lvl(c, 4, 0);
      @(posedge clk_i); #1;
    end
    meas_i = 1'b0; ref_i = 1'b0;
    repeat (6) @(posedge clk_i);
    #1;
    chk(meas_cnt_o == e.m && ref_cnt_o == e.r, "R7", "counts held after done",
        {meas_cnt_o, ref_cnt_o}, {e.m, e.r});
    chk(overflow_o == e.ov && timeout_o == e.to, "R7", "flags held after done",
        {overflow_o, timeout_o}, {e.ov, e.to});
    chk(done_seen == d0 + 1, "R7", "no extra done after result", done_seen - d0, 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk_i);
    #1;
    chk(done_o == 0 && overflow_o == 0 && timeout_o == 0, "R1", "flags after reset",
        {done_o, overflow_o, timeout_o}, 0);
    chk(meas_cnt_o == 0 && ref_cnt_o == 0, "R1", "counts after reset",
        {meas_cnt_o, ref_cnt_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(posedge clk_i);
    #1;
    chk(done_o == 0 && meas_cnt_o == 0 && ref_cnt_o == 0, "R1", "idle after release",
        {done_o, meas_cnt_o, ref_cnt_o}, 0);
    // aligned start, one early coincidence rejected by min gate
    run_meas(10, 0, 4, 0, 5, 200, 1 << 30, -1, "R4");
    // gate opens on a later coincidence
    run_meas(10, 8, 4, 0, 5, 200, 1 << 30, -1, "R3");
    // several rejected coincidences
    run_meas(9, 0, 6, 0, 10, 200, 1 << 30, -1, "R4");
    // zero minimum gate: first coincidence after opening closes
    run_meas(6, 0, 9, 0, 0, 200, 1 << 30, -1, "R3");
    // start pulse in the middle of counting is ignored
    run_meas(10, 0, 4, 0, 9, 200, 1 << 30, 30, "R2");
    // measured signal dies: timeout after min gate
    run_meas(6, 0, 4, 0, 8, 5, 30, -1, "R9");
    // zero timeout: first waiting reference edge ends it
    run_meas(6, 0, 4, 0, 0, 0, 1, -1, "R9");
    // measured count saturates
    run_meas(4, 0, 20, 0, 60, 200, 1 << 30, -1, "R8");
    // normal run again after flags, to see them cleared
    run_meas(8, 0, 4, 0, 3, 200, 1 << 30, -1, "R3");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule